// File: doc/BRIEF.md
# Capture and Compare Timer with Waveform Output

A 32-bit up-counting timer driven from a small register port. Software sets a control word that starts or stops counting, picks an optional power-of-two prescale, selects whether an overflow reloads the counter from a reload register or wraps to zero, and arms a compare against a match register. Overflow, compare and capture events latch into a status register. Each status bit is cleared by writing a one to it, and the interrupt output stays high while any bit is set.

The same control word drives a waveform pin and a capture pin. On the waveform side, the pin can change on overflow only, or on overflow and compare. It either inverts on each such event or gives a one-cycle pulse against a programmable rest level. On the capture side, a synchronized input records the counter value on rising, falling or both edges into one or two capture registers. Software reads the interval as the second capture minus the first: with rising edges this is the period, and with both edges it is the high time. Bus and counting logic share one clock.

Top module: `cpt_timer`

## Requirements
- R1: After reset the control word, counter, status and both capture registers read zero, and the waveform pin and the interrupt are low.
- R2: While control bit 0 is set, the counter (address 1) increases by one per count tick. Once a write clears bit 0, the counter holds its value from the next cycle on.
- R3: With control bit 5 set and prescale field bits [4:2] = p, a count tick occurs once every 2^(p+1) clock cycles, counted from the start. With bit 5 clear, a tick occurs every cycle whatever the field holds.
- R4: A tick at the all-ones count sets status bit 1. The counter then takes the reload value (address 2) when control bit 1 is set, and zero otherwise.
- R5: With control bit 6 set, a tick that brings the counter to the match value (address 3) sets status bit 0. With bit 6 clear, no compare status is raised.
- R6: Writing the status register (address 5) clears each bit written as one. The interrupt output is high exactly while a status bit is set.
- R7: A write of any value to address 4 loads the counter from the reload register. A write to address 1 loads the counter with the written data.
- R8: Field [11:10] picks the waveform trigger: 00 none, 01 overflow, 10 or 11 overflow and compare (a compare counts only with bit 6 set). With bit 12 set the pin inverts on each trigger. With bit 12 clear the pin shows the opposite of the rest level for one cycle after each trigger.
- R9: The waveform pin shows the rest level (control bit 7) while bit 0 is clear, and also while bit 14 gives the pin over to capture.
- R10: Captures happen only while control bit 14 is set. Field [9:8] selects the capture edge: 00 none, 01 rising, 10 falling, 11 both.
- R11: With control bit 13 set, the first capture goes to address 6 and the second to address 7, which also sets status bit 2. Later edges are ignored until status bit 2 is cleared. With bit 13 clear, every capture overwrites address 6 and sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus side and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register (combinational) |
| cap_i | input | 1 | External signal to be measured |
| pwm_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
Counting is run with the prescaler off, with the prescaler on at a divide of four, and with a prescale value present but not enabled. Sampling both one cycle before and on the expected tick separates a correct divider from one that is off by a stage. Overflow is driven from just below all-ones, both with and without reload, so that the two wrap targets can be told apart. The waveform pin is driven under each trigger code in both toggle and pulse form, with a compare that should be ignored under the overflow-only code. Capture is fed a pulse train under rising-only, both-edge, falling-only and no-edge selections, and the capture differences must equal the known input period and high time.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int PRE_W = 3;
  localparam int ST_W  = 3;
  localparam int ST_MATCH = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_CAP   = 2;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_COUNT  = 3'd1,
    A_RELOAD = 3'd2,
    A_MATCH  = 3'd3,
    A_TRIG   = 3'd4,
    A_STAT   = 3'd5,
    A_CAPA   = 3'd6,
    A_CAPB   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic             pin_in;    // 14
    logic             dual;      // 13
    logic             toggle;    // 12
    logic [1:0]       trig;      // 11:10
    logic [1:0]       edge_sel;  // 9:8
    logic             idle;      // 7
    logic             cmp_en;    // 6
    logic             pre_en;    // 5
    logic [PRE_W-1:0] pre;       // 4:2
    logic             reload;    // 1
    logic             run;       // 0
  } ctrl_t;
endpackage

// File: rtl/cpt_prescale.sv
module cpt_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int DIV_W = 1 << PRE_W;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic [PRE_W:0]   sh_amt;

  always_comb begin
    sh_amt = {1'b0, pre} + (PRE_W+1)'(1);
    mask   = (DIV_W'(1) << sh_amt) - DIV_W'(1);
    div_d  = run ? div_q + DIV_W'(1) : '0;
    tick   = run && (!pre_en || ((div_q & mask) == mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cpt_capture.sv
module cpt_capture #(
  parameter int CW   = 32,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          enable,
  input  logic [1:0]    edge_sel,
  input  logic          dual,
  input  logic          clr_done,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap_a,
  output logic [CW-1:0] cap_b,
  output logic          cap_evt
);
  logic [SYNC:0] sh_q;
  logic [1:0]    idx_q, idx_d;
  logic          rise, fall, hit, ld_a, ld_b;

  always_comb begin
    rise = sh_q[SYNC-1] & ~sh_q[SYNC];
    fall = ~sh_q[SYNC-1] & sh_q[SYNC];
    hit  = enable && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
    ld_a = 1'b0;
    ld_b = 1'b0;
    cap_evt = 1'b0;
    idx_d = idx_q;
    if (clr_done) begin
      idx_d = 2'd0;
    end else if (hit) begin
      if (!dual) begin
        ld_a = 1'b1;
        cap_evt = 1'b1;
      end else if (idx_q == 2'd0) begin
        ld_a = 1'b1;
        idx_d = 2'd1;
      end else if (idx_q == 2'd1) begin
        ld_b = 1'b1;
        cap_evt = 1'b1;
        idx_d = 2'd2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= 2'd0;
      cap_a <= '0;
      cap_b <= '0;
    end else begin
      sh_q  <= {sh_q[SYNC-1:0], cap_i};
      idx_q <= idx_d;
      if (ld_a) cap_a <= count;
      if (ld_b) cap_b <= count;
    end
  end
endmodule

// File: rtl/cpt_pwm.sv
module cpt_pwm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pin_in,
  input  logic       idle,
  input  logic       toggle,
  input  logic [1:0] trig,
  input  logic       ovf_evt,
  input  logic       match_evt,
  output logic       pwm_o
);
  logic pwm_q, pwm_d, fire, active;

  always_comb begin
    active = run && !pin_in;
    fire   = ((trig != 2'b00) && ovf_evt) || (trig[1] && match_evt);
    if (!active)     pwm_d = idle;
    else if (toggle) pwm_d = fire ? ~pwm_q : pwm_q;
    else             pwm_d = fire ? ~idle : idle;
    pwm_o = active ? pwm_q : idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end
endmodule

// File: rtl/cpt_timer.sv
module cpt_timer
  import cpt_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  input  logic          cap_i,
  output logic          pwm_o,
  output logic          irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t          ctrl_q;
  logic [CW-1:0]  cnt_q, cnt_d, cnt_step, rld_q, mat_q, cap_a, cap_b;
  logic [ST_W-1:0] sts_q, sts_d, sts_clr;
  logic wr_ctrl, wr_cnt, wr_rld, wr_mat, wr_trig, wr_stat;
  logic tick, wrap, ovf_evt, match_evt, cap_evt;

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_cnt  = wr_en && (addr == A_COUNT);
    wr_rld  = wr_en && (addr == A_RELOAD);
    wr_mat  = wr_en && (addr == A_MATCH);
    wr_trig = wr_en && (addr == A_TRIG);
    wr_stat = wr_en && (addr == A_STAT);
  end

  cpt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
    .pre_en(ctrl_q.pre_en), .pre(ctrl_q.pre), .tick(tick)
  );

  always_comb begin
    wrap     = tick && (&cnt_q);
    cnt_step = wrap ? (ctrl_q.reload ? rld_q : '0) : cnt_q + CW'(1);
    if (wr_cnt)       cnt_d = wr_data;
    else if (wr_trig) cnt_d = rld_q;
    else if (tick)    cnt_d = cnt_step;
    else              cnt_d = cnt_q;
    ovf_evt   = wrap && !wr_cnt && !wr_trig;
    match_evt = tick && ctrl_q.cmp_en && !wr_cnt && !wr_trig && (cnt_step == mat_q);
    sts_clr   = wr_stat ? wr_data[ST_W-1:0] : '0;
    sts_d     = (sts_q & ~sts_clr);
    sts_d[ST_MATCH] = sts_d[ST_MATCH] | match_evt;
    sts_d[ST_OVF]   = sts_d[ST_OVF]   | ovf_evt;
    sts_d[ST_CAP]   = sts_d[ST_CAP]   | cap_evt;
  end

  cpt_capture #(.CW(CW), .SYNC(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .enable(ctrl_q.pin_in),
    .edge_sel(ctrl_q.edge_sel), .dual(ctrl_q.dual), .clr_done(sts_clr[ST_CAP]),
    .count(cnt_q), .cap_a(cap_a), .cap_b(cap_b), .cap_evt(cap_evt)
  );

  cpt_pwm u_pwm (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .pin_in(ctrl_q.pin_in),
    .idle(ctrl_q.idle), .toggle(ctrl_q.toggle), .trig(ctrl_q.trig),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .pwm_o(pwm_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      mat_q  <= '0;
      sts_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_rld)  rld_q  <= wr_data;
      if (wr_mat)  mat_q  <= wr_data;
      cnt_q <= cnt_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    irq_o = |sts_q;
    case (reg_addr_e'(addr))
      A_CTRL:   rd_data = CW'(ctrl_q);
      A_COUNT:  rd_data = cnt_q;
      A_RELOAD: rd_data = rld_q;
      A_MATCH:  rd_data = mat_q;
      A_STAT:   rd_data = CW'(sts_q);
      A_CAPA:   rd_data = cap_a;
      A_CAPB:   rd_data = cap_b;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cpt_timer_chk.sv
module cpt_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [14:0]   ctrl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] mat,
  input logic [2:0]    sts,
  input logic          pwm
);
  logic wcnt;
  assign wcnt = wr_en && (addr == 3'd1 || addr == 3'd4);

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wcnt) |=> $stable(cnt));

  assert_wrap_from_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> ($past(cnt) == {CW{1'b1}}));

  assert_match_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> (cnt == $past(mat)));

  assert_rest_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] || ctrl[14]) |-> (pwm == ctrl[7]));

  assert_capture_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> $past(ctrl[14]));
endmodule

bind cpt_timer cpt_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .ctrl(ctrl_q), .cnt(cnt_q), .mat(mat_q), .sts(sts_q), .pwm(pwm_o)
);

// File: tb/tb_cpt_timer.sv
`timescale 1ns/1ps
module tb_cpt_timer;
  localparam int CW = 32;
  localparam logic [31:0] RUN = 32'h1, AR = 32'h2, PRE_EN = 32'h20, CMP = 32'h40,
    IDLE = 32'h80, EDGE_R = 32'h100, EDGE_F = 32'h200, EDGE_B = 32'h300,
    TRIG_O = 32'h400, TRIG_OM = 32'h800, TOG = 32'h1000, DUAL = 32'h2000, PIN_IN = 32'h4000;

  logic clk, rst_n, wr_en, cap_i, pwm_o, irq_o;
  logic [2:0] addr;
  logic [CW-1:0] wr_data, rd_data;
  int n_chk, n_bad;
  bit done;

  cpt_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
                 .rd_data(rd_data), .cap_i(cap_i), .pwm_o(pwm_o), .irq_o(irq_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] cfg, input logic [31:0] cnt);
    wr(3'd0, cfg & ~RUN);
    wr(3'd5, 32'h7);
    wr(3'd1, cnt);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 count", v, 0);
    rd(3'd5, v); check("R1 status", v, 0);
    rd(3'd6, v); check("R1 capA", v, 0);
    rd(3'd7, v); check("R1 capB", v, 0);
    check("R1 pwm", {31'b0, pwm_o}, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_run_stop();
    logic [31:0] a, b;
    setup(0, 100);
    wr(3'd0, RUN);
    waitc(7);
    rd(3'd1, a); check("R2 count while running", a, 107);
    wr(3'd0, 0);
    rd(3'd1, a); check("R2 count at stop", a, 108);
    waitc(5);
    rd(3'd1, b); check("R2 hold when stopped", b, a);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    setup(PRE_EN | (1 << 2), 0);
    wr(3'd0, RUN | PRE_EN | (1 << 2));
    waitc(15);
    rd(3'd1, v); check("R3 divide by 4 before tick", v, 3);
    waitc(1);
    rd(3'd1, v); check("R3 divide by 4 on tick", v, 4);
    setup(7 << 2, 0);
    wr(3'd0, RUN | (7 << 2));
    waitc(10);
    rd(3'd1, v); check("R3 prescale disabled", v, 10);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    setup(AR, 32'hFFFF_FFFD);
    wr(3'd2, 32'h10);
    wr(3'd0, RUN | AR);
    waitc(2);
    rd(3'd1, v); check("R4 before wrap", v, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R4 no status before wrap", v, 0);
    waitc(1);
    rd(3'd1, v); check("R4 reload on wrap", v, 32'h10);
    rd(3'd5, v); check("R4 overflow status", v, 2);
    check("R6 irq set", {31'b0, irq_o}, 1);
    wr(3'd5, 32'h2);
    rd(3'd5, v); check("R6 W1C clears", v, 0);
    check("R6 irq clear", {31'b0, irq_o}, 0);
    setup(0, 32'hFFFF_FFFF);
    wr(3'd0, RUN);
    waitc(1);
    rd(3'd1, v); check("R4 wrap to zero", v, 0);
    rd(3'd5, v); check("R4 overflow status no reload", v, 2);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    setup(CMP, 0);
    wr(3'd3, 5);
    wr(3'd0, RUN | CMP);
    waitc(4);
    rd(3'd5, v); check("R5 before match", v & 1, 0);
    waitc(1);
    rd(3'd5, v); check("R5 match status", v & 1, 1);
    rd(3'd1, v); check("R5 counter at match", v, 5);
    wr(3'd5, 32'h4);
    rd(3'd5, v); check("R6 writing zero bits keeps status", v & 1, 1);
    setup(0, 0);
    wr(3'd0, RUN);
    waitc(8);
    rd(3'd5, v); check("R5 compare disabled", v, 0);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(3'd0, 0);
    wr(3'd2, 32'h1234);
    wr(3'd4, 32'hDEAD);
    rd(3'd1, v); check("R7 trigger reload", v, 32'h1234);
    wr(3'd1, 32'hABC);
    rd(3'd1, v); check("R7 counter write", v, 32'hABC);
  endtask

  task automatic t_pwm();
    setup(TRIG_O | TOG, 32'hFFFF_FFFE);
    wr(3'd0, RUN | TRIG_O | TOG);
    waitc(1); check("R8 toggle before overflow", {31'b0, pwm_o}, 0);
    waitc(1); check("R8 toggle on overflow", {31'b0, pwm_o}, 1);
    setup(CMP | TRIG_OM | TOG, 0);
    wr(3'd3, 3);
    wr(3'd0, RUN | CMP | TRIG_OM | TOG);
    waitc(2); check("R8 toggle before match", {31'b0, pwm_o}, 0);
    waitc(1); check("R8 toggle on match", {31'b0, pwm_o}, 1);
    setup(CMP | TRIG_O | TOG, 0);
    wr(3'd0, RUN | CMP | TRIG_O | TOG);
    waitc(4); check("R8 overflow-only ignores match", {31'b0, pwm_o}, 0);
    setup(CMP | TRIG_OM | IDLE, 0);
    check("R9 rest level while stopped", {31'b0, pwm_o}, 1);
    wr(3'd0, RUN | CMP | TRIG_OM | IDLE);
    waitc(3); check("R8 pulse on match", {31'b0, pwm_o}, 0);
    waitc(1); check("R8 pulse lasts one cycle", {31'b0, pwm_o}, 1);
    setup(IDLE | PIN_IN | TOG | TRIG_O, 32'hFFFF_FFFE);
    wr(3'd0, RUN | IDLE | PIN_IN | TOG | TRIG_O);
    waitc(3); check("R9 rest level when pin is input", {31'b0, pwm_o}, 1);
  endtask

  task automatic pulse(input int hi, input int lo);
    cap_i = 1'b1; waitc(hi);
    cap_i = 1'b0; waitc(lo);
  endtask

  task automatic t_capture();
    logic [31:0] a, b, v;
    setup(PIN_IN | DUAL | EDGE_R, 0);
    wr(3'd0, RUN | PIN_IN | DUAL | EDGE_R);
    pulse(10, 30);
    rd(3'd5, v); check("R11 no status after first capture", v, 0);
    pulse(10, 5);
    rd(3'd6, a); rd(3'd7, b);
    check("R10 rising period B-A", b - a, 40);
    rd(3'd5, v); check("R11 status after second capture", v & 4, 4);
    pulse(10, 5);
    rd(3'd7, v); check("R11 third edge ignored", v, b);
    setup(PIN_IN | DUAL | EDGE_B, 0);
    wr(3'd0, RUN | PIN_IN | DUAL | EDGE_B);
    pulse(15, 6);
    rd(3'd6, a); rd(3'd7, b);
    check("R10 both-edge high time B-A", b - a, 15);
    setup(PIN_IN | EDGE_F, 0);
    wr(3'd0, RUN | PIN_IN | EDGE_F);
    cap_i = 1'b1; waitc(10);
    rd(3'd5, v); check("R10 falling mode ignores rise", v, 0);
    cap_i = 1'b0; waitc(6);
    rd(3'd5, v); check("R11 single capture on fall", v, 4);
    setup(PIN_IN, 0);
    wr(3'd0, RUN | PIN_IN);
    pulse(8, 6);
    rd(3'd5, v); check("R10 edge none", v, 0);
    setup(DUAL | EDGE_R, 0);
    wr(3'd0, RUN | DUAL | EDGE_R);
    pulse(8, 6); pulse(8, 6);
    rd(3'd5, v); check("R10 pin not input", v, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; cap_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_stop();
    t_prescale();
    t_overflow();
    t_compare();
    t_trigger();
    t_pwm();
    t_capture();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule